// File: doc/BRIEF.md
# Smart Card Session Supervisor

This block supervises one smart card reader slot on behalf of a host. It filters the raw card-present, supply-fault and over-temperature/over-current inputs. When the host asks for a session it powers the card up in steps. When the session ends it powers the card down in the reverse order. The sequencing is a staircase of four enables: supply, I/O, card clock, and finally the hand-over of the card reset contact to the host. Each stair is held for a programmable number of clock cycles.

A single active-low status line goes back to the host, and its meaning depends on the session.

- Outside a session, the line only tells whether a card sits in the slot.
- Inside a session, a low level means a fault was seen. Any fault tears the session down on its own.
- After a fault, the block stays in a latched fault condition until the host withdraws its start request.

A host power-down request is honoured only when no session is running.

The host-side inputs (start, power-down, host reset) are taken as synchronous to the block clock. The card-side inputs are asynchronous and are synchronised and debounced inside the block.

Top module: `sc_session_sup`

## Requirements
- R1: After synchronous reset the block is idle. All four enables are off, the card reset output is low (reset asserted), the power-down indicator is 0, and with no card present the status output is 0.
- R2: A start request (start_n_i = 0) while no card is detected leaves supply_en_o at 0.
- R3: Outside a session, status_n_o equals the debounced card presence: 1 means a card is inserted and 0 means none.
- R4: Activation order. supply_en_o rises one cycle after the start request is seen. io_en_o rises STEP_CYCLES cycles after supply_en_o, and clk_en_o rises STEP_CYCLES cycles after io_en_o. Reset hand-over comes STEP_CYCLES cycles after clk_en_o. A later enable is never on while an earlier one is off.
- R5: card_rst_n_o equals host_rst_n_i only after the reset hand-over; at all other times it is 0.
- R6: When the host raises start_n_i during a session, the card reset is withdrawn one cycle later. clk_en_o then falls STEP_CYCLES cycles after that, io_en_o falls STEP_CYCLES later, and supply_en_o falls STEP_CYCLES after io_en_o.
- R7: A supply fault or a thermal/over-current fault during a session starts deactivation with no host action and drives status_n_o to 0.
- R8: After a fault deactivation, status_n_o stays 0 and no activation starts while start_n_i stays 0, even after the fault clears. Raising start_n_i returns the block to idle, and lowering it again starts a new activation.
- R9: Card removal during a session is treated as a fault, with the same behaviour as R7 and R8.
- R10: A power-down request during a session is ignored: powered_down_o stays 0 and the enables are unchanged. It takes effect once the session has ended.
- R11: A power-down request outside a session sets powered_down_o to 1 and blocks start requests. Releasing it returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_n_i | input | 1 | Host session request, active low |
| pwrdn_i | input | 1 | Host power-down request, active high |
| host_rst_n_i | input | 1 | Host value for the card reset contact |
| card_det_i | input | 1 | Raw card presence, 1 = inserted |
| supply_flt_i | input | 1 | Raw supply fault flag |
| heat_flt_i | input | 1 | Raw thermal or over-current fault flag |
| supply_en_o | output | 1 | Card supply enable |
| io_en_o | output | 1 | Card I/O release |
| clk_en_o | output | 1 | Card clock enable |
| card_rst_n_o | output | 1 | Card reset contact, 0 = reset asserted |
| status_n_o | output | 1 | Active-low presence/fault status to the host |
| powered_down_o | output | 1 | 1 while in power-down |

## Verification
Each cycle spacing of the activation and deactivation staircases is measured separately. Measuring each one, rather than only the total, separates a wrong step order from a wrong delay. A start request with an empty slot and a power-down during a session show whether requests are gated by presence and by session state. Randomly chosen fault sources are injected at random points of an active session, with random host reset toggling. These runs distinguish the status line's presence meaning from its fault meaning. They also show whether the fault latch releases only on a start-request release followed by a new request.

// File: rtl/sc_sup_pkg.sv
package sc_sup_pkg;

    localparam int NUM_STEPS = 4;

    typedef enum logic [5:0] {
        ST_IDLE  = 6'b000001,
        ST_ACT   = 6'b000010,
        ST_ON    = 6'b000100,
        ST_DEACT = 6'b001000,
        ST_FAULT = 6'b010000,
        ST_PD    = 6'b100000
    } sup_state_e;

endpackage

// File: rtl/sc_sync_filter.sv
module sc_sync_filter #(
    parameter int DEB_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic filt_o
);
    localparam int CW = $clog2(DEB_CYCLES + 1);

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic          filt;
        logic [CW-1:0] cnt;
    } flt_t;

    flt_t q, d;

    always_comb begin
        d    = q;
        d.s1 = raw_i;
        d.s2 = q.s1;
        if (q.s2 == q.filt) begin
            d.cnt = '0;
        end else if (q.cnt == CW'(DEB_CYCLES - 1)) begin
            d.filt = q.s2;
            d.cnt  = '0;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign filt_o = q.filt;
endmodule

// File: rtl/sc_enable_map.sv
module sc_enable_map #(
    parameter int STEPS = 4,
    parameter int LW    = 3
) (
    input  logic [LW-1:0]    lvl_i,
    input  logic             host_rst_n_i,
    output logic [STEPS-1:0] en_o,
    output logic             card_rst_n_o
);
    for (genvar i = 0; i < STEPS; i++) begin : g_stair
        assign en_o[i] = (lvl_i > LW'(i));
    end

    assign card_rst_n_o = en_o[STEPS-1] & host_rst_n_i;
endmodule

// File: rtl/sc_session_sup.sv
module sc_session_sup
    import sc_sup_pkg::*;
#(
    parameter int DEB_CYCLES  = 4,
    parameter int STEP_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_n_i,
    input  logic pwrdn_i,
    input  logic host_rst_n_i,
    input  logic card_det_i,
    input  logic supply_flt_i,
    input  logic heat_flt_i,
    output logic supply_en_o,
    output logic io_en_o,
    output logic clk_en_o,
    output logic card_rst_n_o,
    output logic status_n_o,
    output logic powered_down_o
);
    localparam int NUM_IN = 3;
    localparam int LW     = $clog2(NUM_STEPS + 1);
    localparam int TW     = $clog2(STEP_CYCLES + 1);

    typedef struct packed {
        sup_state_e    state;
        logic [LW-1:0] lvl;
        logic [TW-1:0] tmr;
        logic          flt;
    } ctl_t;

    ctl_t q, d;

    logic [NUM_IN-1:0]    raw_in;
    logic [NUM_IN-1:0]    filt_in;
    logic [NUM_STEPS-1:0] en;
    logic                 present_f;
    logic                 fault_now;
    logic                 in_session;
    logic                 step_done;
    sup_state_e           state_q;

    assign raw_in = {heat_flt_i, supply_flt_i, card_det_i};

    for (genvar i = 0; i < NUM_IN; i++) begin : g_in
        sc_sync_filter #(.DEB_CYCLES(DEB_CYCLES)) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_i  (raw_in[i]),
            .filt_o (filt_in[i])
        );
    end

    assign present_f  = filt_in[0];
    assign fault_now  = !filt_in[0] || filt_in[1] || filt_in[2];
    assign state_q    = q.state;
    assign in_session = (q.state == ST_ACT) || (q.state == ST_ON) || (q.state == ST_DEACT);
    assign step_done  = (q.tmr == TW'(STEP_CYCLES - 1));

    always_comb begin
        d = q;
        unique case (q.state)
            ST_IDLE: begin
                d.flt = 1'b0;
                if (pwrdn_i) begin
                    d.state = ST_PD;
                end else if (!start_n_i && present_f) begin
                    d.state = ST_ACT;
                    d.lvl   = LW'(1);
                    d.tmr   = '0;
                end
            end
            ST_ACT, ST_ON: begin
                if (fault_now || start_n_i) begin
                    d.state = ST_DEACT;
                    d.flt   = fault_now;
                    d.lvl   = q.lvl - 1'b1;
                    d.tmr   = '0;
                end else if (q.state == ST_ACT) begin
                    if (step_done) begin
                        d.tmr = '0;
                        d.lvl = q.lvl + 1'b1;
                        if (q.lvl == LW'(NUM_STEPS - 1)) d.state = ST_ON;
                    end else begin
                        d.tmr = q.tmr + 1'b1;
                    end
                end
            end
            ST_DEACT: begin
                if (fault_now) d.flt = 1'b1;
                if (q.lvl == '0) begin
                    d.state = (q.flt || fault_now) ? ST_FAULT : ST_IDLE;
                    d.tmr   = '0;
                end else if (step_done) begin
                    d.tmr = '0;
                    d.lvl = q.lvl - 1'b1;
                end else begin
                    d.tmr = q.tmr + 1'b1;
                end
            end
            ST_FAULT: begin
                if (start_n_i) d.state = ST_IDLE;
            end
            ST_PD: begin
                if (!pwrdn_i) d.state = ST_IDLE;
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.state <= ST_IDLE;
            q.lvl   <= '0;
            q.tmr   <= '0;
            q.flt   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    sc_enable_map #(.STEPS(NUM_STEPS), .LW(LW)) u_map (
        .lvl_i        (q.lvl),
        .host_rst_n_i (host_rst_n_i),
        .en_o         (en),
        .card_rst_n_o (card_rst_n_o)
    );

    assign supply_en_o    = en[0];
    assign io_en_o        = en[1];
    assign clk_en_o       = en[2];
    assign powered_down_o = (q.state == ST_PD);

    always_comb begin
        if (q.state == ST_FAULT)  status_n_o = 1'b0;
        else if (in_session)      status_n_o = !(fault_now || q.flt);
        else                      status_n_o = present_f;
    end
endmodule

// File: rtl/sc_session_sup_chk.sv
module sc_session_sup_chk
    import sc_sup_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input sup_state_e state_q,
    input logic       present_f,
    input logic       supply_en_o,
    input logic       io_en_o,
    input logic       clk_en_o,
    input logic       card_rst_n_o,
    input logic       status_n_o,
    input logic       powered_down_o
);
    assert_state_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(state_q) == 1);

    assert_no_card_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !present_f) |=> (state_q != ST_ACT));

    assert_stair_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (io_en_o |-> supply_en_o) and (clk_en_o |-> io_en_o));

    assert_rst_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        card_rst_n_o |-> (clk_en_o && (state_q == ST_ON || state_q == ST_ACT)));

    assert_fault_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FAULT) |-> (!status_n_o && !supply_en_o));

    assert_pd_outside_R10: assert property (@(posedge clk) disable iff (!rst_n)
        powered_down_o |-> !supply_en_o);
endmodule

bind sc_session_sup sc_session_sup_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .state_q        (state_q),
    .present_f      (present_f),
    .supply_en_o    (supply_en_o),
    .io_en_o        (io_en_o),
    .clk_en_o       (clk_en_o),
    .card_rst_n_o   (card_rst_n_o),
    .status_n_o     (status_n_o),
    .powered_down_o (powered_down_o)
);

// File: tb/tb_sc_session_sup.sv
module tb_sc_session_sup;
    localparam int CLK_PERIOD = 10;
    localparam int DEB        = 4;
    localparam int STEP       = 8;
    localparam int SETTLE     = DEB + 8;
    localparam int WATCHDOG   = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_n = 1'b1, pwrdn = 1'b0, host_rst_n = 1'b0;
    logic card = 1'b0, sflt = 1'b0, hflt = 1'b0;
    logic supply_en, io_en, clk_en, card_rst_n, status_n, pd;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sc_session_sup #(.DEB_CYCLES(DEB), .STEP_CYCLES(STEP)) dut (
        .clk(clk), .rst_n(rst_n), .start_n_i(start_n), .pwrdn_i(pwrdn),
        .host_rst_n_i(host_rst_n), .card_det_i(card), .supply_flt_i(sflt),
        .heat_flt_i(hflt), .supply_en_o(supply_en), .io_en_o(io_en),
        .clk_en_o(clk_en), .card_rst_n_o(card_rst_n), .status_n_o(status_n),
        .powered_down_o(pd)
    );

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic bit sig(int sel);
        case (sel)
            0: return supply_en;
            1: return io_en;
            2: return clk_en;
            default: return card_rst_n;
        endcase
    endfunction

    task automatic wait_for(int sel, bit val, int maxc, output int cyc);
        cyc = 0;
        while (sig(sel) != val && cyc <= maxc) begin
            tick(1);
            cyc++;
        end
    endtask

    function automatic int exp_gap(int idx);
        return (idx == 0) ? 1 : STEP;
    endfunction

    task automatic activate(bit measure);
        int c;
        host_rst_n = 1'b1;
        start_n = 1'b0;
        for (int k = 0; k < 4; k++) begin
            wait_for(k, 1'b1, 4 * STEP, c);
            if (measure) chk(c == exp_gap(k), "R4 activation step gap", c, exp_gap(k));
        end
    endtask

    task automatic host_end(bit measure);
        int c;
        start_n = 1'b1;
        for (int k = 3; k >= 0; k--) begin
            wait_for(k, 1'b0, 4 * STEP, c);
            if (measure) chk(c == exp_gap(3 - k), "R6 deactivation step gap", c, exp_gap(3 - k));
        end
        tick(2);
    endtask

    initial begin
        int c;
        int src, dly;
        void'($urandom(32'h5C5E));
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        chk({supply_en, io_en, clk_en, card_rst_n} == 4'b0, "R1 enables after reset",
            {supply_en, io_en, clk_en, card_rst_n}, 0);
        chk(status_n == 1'b0 && pd == 1'b0, "R1 status/pd after reset", {status_n, pd}, 0);

        // R2 start without card
        start_n = 1'b0;
        tick(SETTLE * 3);
        chk(supply_en == 1'b0, "R2 start ignored with no card", supply_en, 0);
        start_n = 1'b1;

        // R3 presence reporting while idle
        card = 1'b1;
        tick(SETTLE);
        chk(status_n == 1'b1, "R3 status with card", status_n, 1);
        card = 1'b0;
        tick(SETTLE);
        chk(status_n == 1'b0, "R3 status without card", status_n, 0);
        card = 1'b1;
        tick(SETTLE);

        // R4 activation, R5 gating, R6 deactivation
        host_rst_n = 1'b1;
        activate(1'b1);
        for (int k = 0; k < 6; k++) begin
            host_rst_n = k[0];
            tick(1);
            chk(card_rst_n == host_rst_n, "R5 reset follows host when handed", card_rst_n, host_rst_n);
        end
        host_rst_n = 1'b1;
        host_end(1'b1);
        chk(card_rst_n == 1'b0 && status_n == 1'b1, "R5 reset held after session",
            {card_rst_n, status_n}, 1);

        // R5 reset held low during activation even with host high
        start_n = 1'b0;
        tick(STEP + 2);
        chk(card_rst_n == 1'b0 && supply_en == 1'b1, "R5 reset held during activation",
            {supply_en, card_rst_n}, 2);
        host_end(1'b0);

        // R10 power-down during session ignored
        activate(1'b0);
        pwrdn = 1'b1;
        tick(20);
        chk(pd == 1'b0 && clk_en == 1'b1, "R10 power-down ignored in session", {pd, clk_en}, 1);
        host_end(1'b0);
        tick(1);
        chk(pd == 1'b1, "R10 power-down after session end", pd, 1);

        // R11 power-down blocks start
        start_n = 1'b0;
        tick(20);
        chk(supply_en == 1'b0 && pd == 1'b1, "R11 start blocked in power-down", {supply_en, pd}, 1);
        start_n = 1'b1;
        pwrdn = 1'b0;
        tick(2);
        chk(pd == 1'b0, "R11 release power-down", pd, 0);

        // Random fault sessions: R7, R8, R9
        for (int it = 0; it < 9; it++) begin
            src = (it < 3) ? it : int'($urandom_range(2, 0));
            dly = int'($urandom_range(30, 3));
            activate(1'b0);
            for (int k = 0; k < dly; k++) begin
                host_rst_n = 1'($urandom_range(1, 0));
                tick(1);
                if (card_rst_n != host_rst_n)
                    chk(1'b0, "R5 random host reset", card_rst_n, host_rst_n);
            end
            chk(status_n == 1'b1, "R7 status high in healthy session", status_n, 1);
            case (src)
                0: sflt = 1'b1;
                1: hflt = 1'b1;
                default: card = 1'b0;
            endcase
            tick(SETTLE);
            chk(status_n == 1'b0 && card_rst_n == 1'b0,
                (src == 2) ? "R9 removal fault status" : "R7 fault status",
                {status_n, card_rst_n}, 0);
            wait_for(0, 1'b0, 4 * STEP + 4, c);
            chk(supply_en == 1'b0, (src == 2) ? "R9 auto deactivation" : "R7 auto deactivation",
                supply_en, 0);
            sflt = 1'b0;
            hflt = 1'b0;
            card = 1'b1;
            tick(SETTLE * 2);
            chk(status_n == 1'b0 && supply_en == 1'b0, "R8 fault latched while start held",
                {status_n, supply_en}, 0);
            start_n = 1'b1;
            tick(2);
            chk(status_n == 1'b1, "R8 idle after start release", status_n, 1);
            start_n = 1'b0;
            wait_for(0, 1'b1, 4, c);
            chk(c == 1, "R8 new activation after re-request", c, 1);
            host_end(1'b0);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule